// File: doc/BRIEF.md
# Two-Master Preemptive Bus Arbiter

This block decides which of two bus masters owns a shared bus. The grant is a registered one-hot pair, so ownership moves only on a clock edge, and exactly one master holds the bus at all times. When both masters want the bus, the owner keeps it until its time slice runs out. The slice is a power of two of quanta, and a quantum is either one clock or one completed transfer. When the slice runs out, arbitration chooses the next owner. That choice is plain alternation, or it is decided by a two-level priority with alternation between equals.

A fixed-length burst that is still in progress can shield the owner from losing the bus. A two-bit setting chooses which burst lengths are protected. When nobody requests, the bus is parked on a selectable master. All of these behaviours come from one 13-bit configuration word. Integration logic drives the word and may change it at any time.

Configuration word layout, bit 0 first: `qexp` [3:0], `by_xfer` [4], `split` [6:5], `uniform` [7], `park` [8], `prio0` [10:9], `prio1` [12:11].

Top module: `arb2_preempt`

## Requirements
- R1: During and after synchronous reset, `grant` is one-hot. Reset sets `grant` to the master named by `park`: 0 gives `grant`=01, 1 gives `grant`=10.
- R2: The settings are `by_xfer`=0 and `qexp`=n with n from 0 to 14. When both masters request and no burst protects the owner, each grant after the first lasts exactly 2^n clocks.
- R3: The settings are `by_xfer`=1 and `qexp`=n below 15. Each clock with `xfer_done`=1 is one quantum. A contended grant ends on the edge that completes its 2^n-th transfer, so with a transfer every 3 clocks a grant lasts 3*2^n clocks.
- R4: With `qexp`=15, an owner that keeps requesting never loses the grant, whatever the other master does.
- R5: With `uniform`=1, contended grants alternate between the masters whatever the priority fields hold.
- R6: With `uniform`=0, a priority field of 10 means high and every other value means low. When the slice expires, a high-priority owner that faces a low-priority requester keeps the bus. A low-priority owner that faces a high-priority requester hands it over.
- R7: With `uniform`=0 and equal priority levels, contended grants alternate every 2^n quanta, as in R2.
- R8: If the owner stops requesting while the other master requests, the grant moves to the other master at the next edge, whatever the quantum count. A protected burst is the one exception.
- R9: If neither master requests, the grant moves to the master named by `park` at the next edge, unless a protected burst is in progress.
- R10: `burst_more`=1 marks a fixed-length burst in progress with `burst_beats` beats. The `split` setting decides whether the burst may be split. 00 always allows a split. 01 allows it only when beats > 4. 10 allows it only when beats > 8. 11 never allows it. While a burst that may not be split is in progress, the grant does not change.
- R11: When `burst_more` falls after a protected burst, any preemption or hand-over that was held back happens at the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Bus requests, bit i from master i |
| cfg | input | 13 | Configuration word (layout above) |
| burst_beats | input | 5 | Beat count of the owner's current fixed-length burst |
| burst_more | input | 1 | Owner is inside a fixed-length burst with beats still pending |
| xfer_done | input | 1 | A bus transfer completes this clock |
| grant | output | 2 | One-hot bus grant, bit i to master i |

## Verification
The slice length is swept over many exponents, both in clock quanta and with a transfer strobe every third clock. This separates an off-by-one counter or a counter that fails to restart from correct timing. Priority encodings are tried high against low, low against high, and at equal levels that include the two undefined codes. These runs show whether the winner depends on the level or only on alternation. Every split setting is tried against burst lengths on both sides of 4 and 8, which exposes a wrong boundary comparison. Request drops, idle parking on either master and the non-preemptive setting show that hand-over ignores the quantum count while contention does not.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NM      = 2;
    localparam int EXP_W   = 4;
    localparam int BEAT_W  = 5;
    localparam int PRIO_W  = 2;
    localparam int CNT_W   = 16;
    localparam int CFG_W   = EXP_W + 1 + 2 + 1 + 1 + NM * PRIO_W;
    localparam logic [EXP_W-1:0] QEXP_HOLD = '1;
    localparam logic [PRIO_W-1:0] PRIO_HIGH = 2'b10;

    typedef enum logic [1:0] {
        SPLIT_ALL  = 2'b00,
        SPLIT_GT4  = 2'b01,
        SPLIT_GT8  = 2'b10,
        SPLIT_NONE = 2'b11
    } split_e;

    typedef struct packed {
        logic [PRIO_W-1:0] prio1;
        logic [PRIO_W-1:0] prio0;
        logic              park;
        logic              uniform;
        split_e            split;
        logic              by_xfer;
        logic [EXP_W-1:0]  qexp;
    } cfg_t;

    function automatic logic is_high(input logic [PRIO_W-1:0] p);
        return p == PRIO_HIGH;
    endfunction

    function automatic logic may_split(input split_e m, input logic [BEAT_W-1:0] beats);
        case (m)
            SPLIT_ALL: return 1'b1;
            SPLIT_GT4: return beats > BEAT_W'(4);
            SPLIT_GT8: return beats > BEAT_W'(8);
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic [CNT_W:0] slice_len(input logic [EXP_W-1:0] e);
        return (CNT_W+1)'(1) << e;
    endfunction

endpackage

// File: rtl/arb_quantum_ctr.sv
module arb_quantum_ctr
    import arb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [EXP_W-1:0] qexp,
    output logic             expire
);
    logic [CNT_W-1:0] count_q;
    logic [CNT_W:0]   sum;

    always_comb begin
        sum    = {1'b0, count_q} + (CNT_W+1)'(tick);
        expire = (qexp != QEXP_HOLD) && (sum >= slice_len(qexp));
    end

    always_ff @(posedge clk) begin
        if (rst || restart)
            count_q <= '0;
        else if (count_q != '1)
            count_q <= sum[CNT_W-1:0];
    end

    // R2
    ctr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && tick && count_q != '1) |=> count_q == $past(count_q) + 1'b1);

    // R3
    ctr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!restart && !tick) |=> $stable(count_q));

endmodule

// File: rtl/arb_burst_guard.sv
module arb_burst_guard
    import arb_pkg::*;
(
    input  split_e            split,
    input  logic [BEAT_W-1:0] beats,
    input  logic              more,
    output logic              locked
);
    always_comb locked = more && !may_split(split, beats);

    // R10
    always_comb begin
        if (split == SPLIT_NONE)
            lock_none_chk: assert (locked == more);
    end
endmodule

// File: rtl/arb_decide.sv
module arb_decide
    import arb_pkg::*;
(
    input  cfg_t          cfg,
    input  logic [NM-1:0] req,
    input  logic          owner,
    input  logic          expire,
    input  logic          locked,
    output logic          next_owner,
    output logic          arb_point
);
    logic [NM-1:0] hi;

    generate
        for (genvar i = 0; i < NM; i++) begin : g_lvl
            if (i == 0) begin : g_m0
                assign hi[i] = is_high(cfg.prio0);
            end else begin : g_m1
                assign hi[i] = is_high(cfg.prio1);
            end
        end
    endgenerate

    logic other, own_req, oth_req, owner_wins;

    always_comb begin
        other      = !owner;
        own_req    = req[owner];
        oth_req    = req[other];
        owner_wins = !cfg.uniform && hi[owner] && !hi[other];
        next_owner = owner;
        arb_point  = 1'b0;
        if (!locked) begin
            if (!own_req && oth_req) begin
                next_owner = other;
                arb_point  = 1'b1;
            end else if (!own_req && !oth_req) begin
                next_owner = cfg.park;
                arb_point  = (cfg.park != owner);
            end else if (own_req && oth_req && expire) begin
                arb_point  = 1'b1;
                next_owner = owner_wins ? owner : other;
            end
        end
    end
endmodule

// File: rtl/arb2_preempt.sv
module arb2_preempt
    import arb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NM-1:0]     req,
    input  logic [CFG_W-1:0]  cfg,
    input  logic [BEAT_W-1:0] burst_beats,
    input  logic              burst_more,
    input  logic              xfer_done,
    output logic [NM-1:0]     grant
);
    cfg_t c;
    logic owner, next_owner, arb_point, expire, locked, tick;
    logic [NM-1:0] grant_q;

    always_comb begin
        c     = cfg_t'(cfg);
        owner = grant_q[1];
        tick  = c.by_xfer ? xfer_done : 1'b1;
    end

    arb_quantum_ctr u_ctr (
        .clk(clk), .rst(rst), .restart(arb_point), .tick(tick),
        .qexp(c.qexp), .expire(expire)
    );

    arb_burst_guard u_guard (
        .split(c.split), .beats(burst_beats), .more(burst_more), .locked(locked)
    );

    arb_decide u_dec (
        .cfg(c), .req(req), .owner(owner), .expire(expire), .locked(locked),
        .next_owner(next_owner), .arb_point(arb_point)
    );

    always_ff @(posedge clk) begin
        if (rst)
            grant_q <= c.park ? 2'b10 : 2'b01;
        else if (arb_point)
            grant_q <= next_owner ? 2'b10 : 2'b01;
    end

    assign grant = grant_q;

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(grant_q) == 1);

    // R10
    burst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        locked |=> $stable(grant_q));

    // R4
    no_preempt_chk: assert property (@(posedge clk) disable iff (rst)
        (req[owner] && c.qexp == QEXP_HOLD) |=> $stable(grant_q));

    // R8
    handoff_chk: assert property (@(posedge clk) disable iff (rst)
        (!locked && !req[owner] && req[!owner]) |=> grant_q != $past(grant_q));

    // R9
    park_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (req == 2'b00 && !locked) |=> grant_q == (2'b01 << $past(c.park)));

    // R6
    prio_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!c.uniform && req == 2'b11 && is_high(owner ? c.prio1 : c.prio0)
         && !is_high(owner ? c.prio0 : c.prio1)) |=> $stable(grant_q));

endmodule

// File: tb/sim_arb2_preempt.sv
module sim_arb2_preempt;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  req = 2'b00;
    logic [12:0] cfg = '0;
    logic [4:0]  burst_beats = '0;
    logic        burst_more = 1'b0;
    logic        xfer_done = 1'b0;
    logic [1:0]  grant;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    arb2_preempt u0 (
        .clk(clk), .rst(rst), .req(req), .cfg(cfg), .burst_beats(burst_beats),
        .burst_more(burst_more), .xfer_done(xfer_done), .grant(grant)
    );

    function automatic logic [12:0] mk(input logic [1:0] p1, input logic [1:0] p0,
                                       input logic park, input logic uni,
                                       input logic [1:0] split, input logic byx,
                                       input logic [3:0] qexp);
        return {p1, p0, park, uni, split, byx, qexp};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [12:0] c, input logic [1:0] r);
        cfg = c; req = r; burst_more = 1'b0; xfer_done = 1'b0; rst = 1'b1;
        repeat (2) cyc();
        rst = 1'b0;
    endtask

    // interval between the 2nd and 3rd grant change; xper>0 pulses xfer_done
    task automatic measure(input int maxc, input int xper, output int iv);
        int changes = 0, t1 = 0;
        logic [1:0] prev = grant;
        iv = -1;
        for (int c = 1; c <= maxc; c++) begin
            xfer_done = (xper > 0) ? ((c % xper) == 0) : 1'b0;
            cyc();
            if (grant != prev) begin
                changes++;
                if (changes == 2) t1 = c;
                if (changes == 3) begin iv = c - t1; break; end
            end
            prev = grant;
        end
        xfer_done = 1'b0;
    endtask

    task automatic count_changes(input int n, output int ch);
        logic [1:0] prev = grant;
        ch = 0;
        for (int c = 0; c < n; c++) begin
            cyc();
            if (grant != prev) ch++;
            prev = grant;
        end
    endtask

    initial begin
        int iv, ch, lim;
        bit lk;
        // R1 reset state for both park choices
        for (int p = 0; p < 2; p++) begin
            do_reset(mk(2'b01, 2'b01, p[0], 1'b1, 2'b10, 1'b0, 4'd4), 2'b00);
            check(grant == (p ? 2'b10 : 2'b01), "R1 reset park", grant, p ? 2 : 1);
        end

        // R2 clock quanta sweep, R5 uniform ignores priority
        for (int n = 0; n <= 6; n++) begin
            do_reset(mk(2'b01, 2'b10, 1'b0, 1'b1, 2'b11, 1'b0, n[3:0]), 2'b11);
            measure(8 * (1 << n) + 20, 0, iv);
            check(iv == (1 << n), "R2/R5 clock slice", iv, 1 << n);
        end
        do_reset(mk(2'b10, 2'b10, 1'b0, 1'b1, 2'b11, 1'b0, 4'd14), 2'b11);
        measure(3 * 16384 + 20, 0, iv);
        check(iv == 16384, "R2 clock slice n=14", iv, 16384);

        // R3 transfer quanta, one transfer every 3 clocks
        for (int n = 0; n <= 4; n++) begin
            do_reset(mk(2'b01, 2'b01, 1'b0, 1'b1, 2'b11, 1'b1, n[3:0]), 2'b11);
            measure(3 * 4 * (1 << n) + 20, 3, iv);
            check(iv == 3 * (1 << n), "R3 transfer slice", iv, 3 * (1 << n));
        end

        // R4 non-preemptive
        do_reset(mk(2'b01, 2'b01, 1'b1, 1'b1, 2'b11, 1'b0, 4'd15), 2'b11);
        count_changes(300, ch);
        check(ch == 0, "R4 hold forever", ch, 0);
        check(grant == 2'b10, "R4 owner kept", grant, 2);

        // R6 high owner keeps bus
        do_reset(mk(2'b10, 2'b01, 1'b1, 1'b0, 2'b11, 1'b0, 4'd1), 2'b11);
        count_changes(60, ch);
        check(ch == 0 && grant == 2'b10, "R6 high owner keeps", ch, 0);
        // R6 low owner yields to high, then high keeps
        do_reset(mk(2'b10, 2'b01, 1'b0, 1'b0, 2'b11, 1'b0, 4'd1), 2'b11);
        count_changes(60, ch);
        check(ch == 1 && grant == 2'b10, "R6 low owner yields", ch, 1);
        // R6 code 11 is low against 10
        do_reset(mk(2'b11, 2'b10, 1'b0, 1'b0, 2'b11, 1'b0, 4'd0), 2'b11);
        count_changes(40, ch);
        check(ch == 0 && grant == 2'b01, "R6 code 11 is low", ch, 0);

        // R7 equal levels alternate (10/10, 01/01, 11/00)
        for (int k = 0; k < 3; k++) begin
            logic [1:0] a, b;
            a = (k == 0) ? 2'b10 : (k == 1) ? 2'b01 : 2'b11;
            b = (k == 0) ? 2'b10 : (k == 1) ? 2'b01 : 2'b00;
            do_reset(mk(a, b, 1'b0, 1'b0, 2'b11, 1'b0, 4'd2), 2'b11);
            measure(60, 0, iv);
            check(iv == 4, "R7 equal priority alternation", iv, 4);
        end

        // R8 hand-over ignores the count (non-preemptive slice)
        do_reset(mk(2'b01, 2'b01, 1'b0, 1'b1, 2'b11, 1'b0, 4'd15), 2'b00);
        req = 2'b10; cyc();
        check(grant == 2'b10, "R8 hand-over to m1", grant, 2);
        req = 2'b01; cyc();
        check(grant == 2'b01, "R8 hand-over to m0", grant, 1);

        // R9 idle parking on either master
        for (int p = 0; p < 2; p++) begin
            do_reset(mk(2'b01, 2'b01, p[0], 1'b1, 2'b11, 1'b0, 4'd15), p ? 2'b01 : 2'b10);
            cyc();
            check(grant == (p ? 2'b01 : 2'b10), "R8 requester takes bus", grant, p ? 1 : 2);
            req = 2'b00; cyc();
            check(grant == (p ? 2'b10 : 2'b01), "R9 park when idle", grant, p ? 2 : 1);
        end

        // R10/R11 burst protection sweep
        for (int m = 0; m < 4; m++) begin
            for (int bi = 0; bi < 5; bi++) begin
                int b;
                b = (bi == 0) ? 4 : (bi == 1) ? 5 : (bi == 2) ? 8 : (bi == 3) ? 9 : 16;
                lim = (m == 1) ? 4 : (m == 2) ? 8 : 0;
                lk = (m == 3) ? 1'b1 : (m == 0) ? 1'b0 : (b <= lim);
                do_reset(mk(2'b01, 2'b01, 1'b0, 1'b1, m[1:0], 1'b0, 4'd0), 2'b11);
                burst_beats = b[4:0];
                burst_more = 1'b1;
                rst = 1'b1; cyc(); rst = 1'b0;
                count_changes(20, ch);
                if (lk) begin
                    check(ch == 0, $sformatf("R10 locked split=%0d beats=%0d", m, b), ch, 0);
                    burst_more = 1'b0;
                    count_changes(1, ch);
                    check(ch == 1, "R11 release after burst", ch, 1);
                end else begin
                    check(ch > 0, $sformatf("R10 splittable split=%0d beats=%0d", m, b), ch, 1);
                end
                burst_more = 1'b0;
            end
        end

        done = 1'b1;
    end

    initial begin
        int cnt = 0;
        while (!done && cnt < 190000) begin
            @(posedge clk);
            cnt++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cnt, 0);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule